// File: doc/BRIEF.md
# Dual Byte FIFO with Pseudo-DMA Port

This block buffers bytes for a storage-bus controller in two separate queues: a data queue of 16 entries and a command queue of 32 entries, both 8 bits wide. Software reaches them through a byte register port. A pseudo-DMA engine reaches them through a second port that moves either one byte or a 16-bit halfword per request. A level input called command mode steers register writes and all pseudo-DMA traffic to the command queue. When it is low, that traffic goes to the data queue. Register reads always take from the data queue.

Each pseudo-DMA write byte is gated and counted by a loadable transfer counter. After every pseudo-DMA request the block gives a one-cycle service strobe when the port needs attention. For a write this means the count has run out or the data queue is nearly full. For a read it means the data queue is nearly empty. A register read can return the data-queue fill level instead of a byte. A flush input empties the data queue. Overflow and underflow never stall: a push into a full queue is dropped and flagged, and a pop from an empty queue yields zero.

Both request ports are valid/ready. A request is taken on a rising edge where valid and ready are both high. The pseudo-DMA port has priority. The register ports drop ready while a pseudo-DMA request is pending or a halfword is half done, and a register read also waits for a pending register write. The response of a read comes as a one-cycle valid pulse and has no ready. The flush, transfer-count load and command-mode inputs are plain controls.

Top module: `dual_fifo_pdma`

## Requirements
- R1: After reset both queue levels and the transfer count are 0, pdma_ready is 1, and svc_strobe, overrun, reg_rsp_valid and pdma_rsp_valid are 0.
- R2: Bytes leave a queue in the order they were pushed. A push into a full queue is dropped and leaves level and contents unchanged, and overrun is high for the one cycle after that edge.
- R3: A pop from an empty queue returns 0x00 and leaves the level at 0.
- R4: While cmd_mode is 1, register writes and pseudo-DMA reads and writes use the command queue. While it is 0 they use the data queue. Register data reads always pop the data queue.
- R5: A halfword pseudo-DMA write (pdma_wide=1) pushes bits 15:8 and then bits 7:0 on two successive edges. A halfword read places the first popped byte in bits 15:8 and the second in bits 7:0. pdma_ready is 0 during the cycle between. A byte read returns its byte in bits 7:0 with bits 15:8 zero. The read response is valid for one cycle after the last byte edge.
- R6: A pseudo-DMA write byte is ignored when the transfer count is 0. Otherwise the count drops by 1, even when the queue is full and the byte is dropped.
- R7: In the cycle after a pseudo-DMA write completes, svc_strobe is 1 exactly when the transfer count is 0 or fewer than 2 data-queue entries are free.
- R8: In the cycle after a pseudo-DMA read completes, svc_strobe is 1 exactly when fewer than 2 data-queue entries are used.
- R9: A register read with reg_rd_flags=1 returns the data-queue level in bits 4:0 with bits 7:5 zero, and pops nothing.
- R10: A flush pulse empties the data queue. It wins over a push on the same edge and leaves the command queue untouched.
- R11: reg_wr_ready and reg_rd_ready are 0 while pdma_valid is 1 or a halfword is in progress. reg_rd_ready is also 0 while reg_wr_valid is 1.
- R12: tc_load sets the transfer count to tc_load_val on the next edge and takes precedence over a decrement on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mode | input | 1 | 1 steers writes and pseudo-DMA to the command queue |
| flush | input | 1 | Empties the data queue |
| tc_load | input | 1 | Loads the transfer count |
| tc_load_val | input | 16 | Value for tc_load |
| tc_value | output | 16 | Current transfer count |
| reg_wr_valid | input | 1 | Register write request |
| reg_wr_ready | output | 1 | Register write may be taken |
| reg_wr_data | input | 8 | Byte to push |
| reg_rd_valid | input | 1 | Register read request |
| reg_rd_ready | output | 1 | Register read may be taken |
| reg_rd_flags | input | 1 | 1 reads the level, 0 pops the data queue |
| reg_rsp_valid | output | 1 | Register read response pulse |
| reg_rsp_data | output | 8 | Register read response byte |
| pdma_valid | input | 1 | Pseudo-DMA request |
| pdma_ready | output | 1 | Pseudo-DMA request may be taken |
| pdma_write | input | 1 | 1 write, 0 read |
| pdma_wide | input | 1 | 1 halfword, 0 byte |
| pdma_wdata | input | 16 | Write data |
| pdma_rsp_valid | output | 1 | Pseudo-DMA read response pulse |
| pdma_rsp_data | output | 16 | Pseudo-DMA read data |
| svc_strobe | output | 1 | Service request after a pseudo-DMA request |
| overrun | output | 1 | A push was dropped on the previous edge |
| data_level | output | 5 | Data queue fill level |
| cmd_level | output | 6 | Command queue fill level |

## Verification
Directed cases fill the data queue past its end and then drain it. This separates ordering from the drop-on-full rule, and reading the empty queue exposes the zero result. Halfword writes with a transfer count of 1 tell the high byte from the low byte, because only the high byte may land. Halfword reads tell the byte lanes apart and show the stall cycle. A flush on the same edge as a register push, and a count load on the same edge as a pseudo-DMA write, show which action wins. Seeded random mixes of all operations, with command mode toggling, run the two queues side by side under a bench model. This shows that traffic in one mode never moves the other queue, and that the service strobe follows the levels on both sides of its thresholds.

// File: rtl/dual_fifo_pkg.sv
package dual_fifo_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_LOW  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic       valid;
    logic       write;
    logic       to_cmd;
    logic [7:0] wbyte;
  } byte_op_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          drop
);
  localparam logic [CW-1:0] FULL_LEVEL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX   = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == FULL_LEVEL);
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign drop    = push && full;
  assign level   = count;
  assign head    = (count == '0) ? 8'h00 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         zero
);
  assign zero = (value == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              value <= '0;
    else if (load)           value <= load_val;
    else if (dec && !zero)   value <= value - W'(1);
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import dual_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [15:0] req_wdata,
  input  logic        cmd_mode,
  input  logic [7:0]  pop_byte,
  output byte_op_t    op,
  output logic        done,
  output logic        done_write,
  output logic        rsp_valid,
  output logic [15:0] rsp_data
);
  seq_state_e state;
  logic       hold_write, hold_cmd;
  logic [7:0] hold_lo, hi_byte;
  logic       accept, in_low, last_op;

  assign req_ready = (state == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_low    = (state == SEQ_LOW);
  assign last_op   = in_low || (accept && !req_wide);

  always_comb begin
    op.valid  = accept || in_low;
    op.write  = in_low ? hold_write : req_write;
    op.to_cmd = in_low ? hold_cmd   : cmd_mode;
    if (in_low)        op.wbyte = hold_lo;
    else if (req_wide) op.wbyte = req_wdata[15:8];
    else               op.wbyte = req_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      hold_write <= 1'b0;
      hold_cmd   <= 1'b0;
      hold_lo    <= 8'h00;
      hi_byte    <= 8'h00;
      done       <= 1'b0;
      done_write <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= 16'h0000;
    end else begin
      done      <= last_op;
      rsp_valid <= last_op && !op.write;
      if (last_op) done_write <= op.write;
      if (accept) begin
        hold_write <= req_write;
        hold_cmd   <= cmd_mode;
        hold_lo    <= req_wdata[7:0];
        hi_byte    <= pop_byte;
      end
      if (last_op && !op.write) begin
        rsp_data <= in_low ? {hi_byte, pop_byte} : {8'h00, pop_byte};
      end
      unique case (state)
        SEQ_IDLE: if (accept && req_wide) state <= SEQ_LOW;
        SEQ_LOW:  state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_fifo_pdma.sv
module dual_fifo_pdma
  import dual_fifo_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int TC_W       = 16,
  localparam int DCW = $clog2(DATA_DEPTH + 1),
  localparam int CCW = $clog2(CMD_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_mode,
  input  logic            flush,
  input  logic            tc_load,
  input  logic [TC_W-1:0] tc_load_val,
  output logic [TC_W-1:0] tc_value,
  input  logic            reg_wr_valid,
  output logic            reg_wr_ready,
  input  logic [7:0]      reg_wr_data,
  input  logic            reg_rd_valid,
  output logic            reg_rd_ready,
  input  logic            reg_rd_flags,
  output logic            reg_rsp_valid,
  output logic [7:0]      reg_rsp_data,
  input  logic            pdma_valid,
  output logic            pdma_ready,
  input  logic            pdma_write,
  input  logic            pdma_wide,
  input  logic [15:0]     pdma_wdata,
  output logic            pdma_rsp_valid,
  output logic [15:0]     pdma_rsp_data,
  output logic            svc_strobe,
  output logic            overrun,
  output logic [DCW-1:0]  data_level,
  output logic [CCW-1:0]  cmd_level
);
  localparam logic [DCW-1:0] DATA_FULL = DCW'(DATA_DEPTH);
  localparam logic [DCW-1:0] LOW_MARK  = DCW'(2);

  byte_op_t   op;
  logic       seq_done, seq_done_wr;
  logic       tc_zero, pdma_wr_ok, pdma_rd_go;
  logic       reg_wr_go, reg_rd_go;
  logic       d_push, d_pop, d_full, d_drop;
  logic       c_push, c_pop, c_full, c_drop;
  logic [7:0] d_head, c_head, d_wbyte, c_wbyte, pop_byte;
  logic [DCW-1:0] data_free;

  // pseudo-DMA port has priority over the register port
  assign reg_wr_ready = pdma_ready && !pdma_valid;
  assign reg_rd_ready = reg_wr_ready && !reg_wr_valid;
  assign reg_wr_go    = reg_wr_valid && reg_wr_ready;
  assign reg_rd_go    = reg_rd_valid && reg_rd_ready;

  pdma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (pdma_valid),
    .req_ready  (pdma_ready),
    .req_write  (pdma_write),
    .req_wide   (pdma_wide),
    .req_wdata  (pdma_wdata),
    .cmd_mode   (cmd_mode),
    .pop_byte   (pop_byte),
    .op         (op),
    .done       (seq_done),
    .done_write (seq_done_wr),
    .rsp_valid  (pdma_rsp_valid),
    .rsp_data   (pdma_rsp_data)
  );

  xfer_count #(.W(TC_W)) u_tc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tc_load),
    .load_val (tc_load_val),
    .dec      (pdma_wr_ok),
    .value    (tc_value),
    .zero     (tc_zero)
  );

  assign pdma_wr_ok = op.valid && op.write && !tc_zero;
  assign pdma_rd_go = op.valid && !op.write;

  assign d_push  = (pdma_wr_ok && !op.to_cmd) || (reg_wr_go && !cmd_mode);
  assign c_push  = (pdma_wr_ok &&  op.to_cmd) || (reg_wr_go &&  cmd_mode);
  assign d_wbyte = op.valid ? op.wbyte : reg_wr_data;
  assign c_wbyte = op.valid ? op.wbyte : reg_wr_data;
  assign d_pop   = (pdma_rd_go && !op.to_cmd) || (reg_rd_go && !reg_rd_flags);
  assign c_pop   = pdma_rd_go && op.to_cmd;
  assign pop_byte = op.to_cmd ? c_head : d_head;

  byte_fifo #(.DEPTH(DATA_DEPTH)) u_data_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush),
    .push      (d_push),
    .push_data (d_wbyte),
    .pop       (d_pop),
    .head      (d_head),
    .level     (data_level),
    .full      (d_full),
    .drop      (d_drop)
  );

  byte_fifo #(.DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (1'b0),
    .push      (c_push),
    .push_data (c_wbyte),
    .pop       (c_pop),
    .head      (c_head),
    .level     (cmd_level),
    .full      (c_full),
    .drop      (c_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rsp_valid <= 1'b0;
      reg_rsp_data  <= 8'h00;
      overrun       <= 1'b0;
    end else begin
      reg_rsp_valid <= reg_rd_go;
      overrun       <= (d_drop && !(d_full && flush)) || c_drop;
      if (reg_rd_go) reg_rsp_data <= reg_rd_flags ? 8'(data_level) : d_head;
    end
  end

  assign data_free  = DATA_FULL - data_level;
  assign svc_strobe = seq_done &&
                      (seq_done_wr ? (tc_zero || (data_free < LOW_MARK))
                                   : (data_level < LOW_MARK));
endmodule

// File: rtl/dual_fifo_pdma_checker.sv
module dual_fifo_pdma_checker #(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  parameter int TC_W       = 16,
  localparam int DCW = $clog2(DATA_DEPTH + 1),
  localparam int CCW = $clog2(CMD_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            tc_load,
  input logic [TC_W-1:0] tc_load_val,
  input logic [TC_W-1:0] tc_value,
  input logic            reg_rd_valid,
  input logic            reg_rd_ready,
  input logic            reg_rd_flags,
  input logic            reg_rsp_valid,
  input logic [7:0]      reg_rsp_data,
  input logic            pdma_valid,
  input logic            pdma_ready,
  input logic            pdma_write,
  input logic            pdma_wide,
  input logic            overrun,
  input logic [DCW-1:0]  data_level,
  input logic [CCW-1:0]  cmd_level
);
  localparam logic [DCW-1:0] D_FULL = DCW'(DATA_DEPTH);
  localparam logic [CCW-1:0] C_FULL = CCW'(CMD_DEPTH);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_level <= D_FULL) && (cmd_level <= C_FULL));

  p_overrun_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (($past(data_level) == D_FULL) || ($past(cmd_level) == C_FULL)));

  p_empty_pop_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_valid && reg_rd_ready && !reg_rd_flags && (data_level == '0))
      |=> (reg_rsp_valid && (reg_rsp_data == 8'h00)));

  p_wide_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pdma_valid && pdma_ready && pdma_wide) |=> !pdma_ready);

  p_tc_zero_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pdma_valid && pdma_ready && pdma_write && !pdma_wide &&
     (tc_value == '0) && !tc_load && !flush)
      |=> ((tc_value == '0) && $stable(data_level) && $stable(cmd_level)));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (data_level == '0));

  p_tc_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tc_load |=> (tc_value == $past(tc_load_val)));
endmodule

bind dual_fifo_pdma dual_fifo_pdma_checker #(
  .DATA_DEPTH (DATA_DEPTH),
  .CMD_DEPTH  (CMD_DEPTH),
  .TC_W       (TC_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .tc_load      (tc_load),
  .tc_load_val  (tc_load_val),
  .tc_value     (tc_value),
  .reg_rd_valid (reg_rd_valid),
  .reg_rd_ready (reg_rd_ready),
  .reg_rd_flags (reg_rd_flags),
  .reg_rsp_valid(reg_rsp_valid),
  .reg_rsp_data (reg_rsp_data),
  .pdma_valid   (pdma_valid),
  .pdma_ready   (pdma_ready),
  .pdma_write   (pdma_write),
  .pdma_wide    (pdma_wide),
  .overrun      (overrun),
  .data_level   (data_level),
  .cmd_level    (cmd_level)
);

// File: tb/dual_fifo_pdma_bench.sv
module dual_fifo_pdma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_mode = 1'b0, flush = 1'b0, tc_load = 1'b0;
  logic [15:0] tc_load_val = '0, tc_value;
  logic        reg_wr_valid = 1'b0, reg_wr_ready;
  logic [7:0]  reg_wr_data = '0;
  logic        reg_rd_valid = 1'b0, reg_rd_ready, reg_rd_flags = 1'b0;
  logic        reg_rsp_valid;
  logic [7:0]  reg_rsp_data;
  logic        pdma_valid = 1'b0, pdma_ready, pdma_write = 1'b0, pdma_wide = 1'b0;
  logic [15:0] pdma_wdata = '0;
  logic        pdma_rsp_valid;
  logic [15:0] pdma_rsp_data;
  logic        svc_strobe, overrun;
  logic [4:0]  data_level;
  logic [5:0]  cmd_level;

  always #2.5 clk = ~clk;

  dual_fifo_pdma u_dual_fifo_pdma (.*);

  int checks = 0, failures = 0;
  logic [7:0] dq[$], cq[$];
  int unsigned tc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [7:0] model_pop(bit c);
    logic [7:0] b = 8'h00;
    if (c) begin if (cq.size() > 0) b = cq.pop_front(); end
    else   begin if (dq.size() > 0) b = dq.pop_front(); end
    return b;
  endfunction

  function automatic bit model_push(bit c, logic [7:0] b);
    if (c) begin if (cq.size() >= 32) return 1'b1; cq.push_back(b); end
    else   begin if (dq.size() >= 16) return 1'b1; dq.push_back(b); end
    return 1'b0;
  endfunction

  task automatic check_state(string tag);
    chk({tag, " R2 data_level"}, 32'(data_level), 32'(dq.size()));
    chk({tag, " R4 cmd_level"}, 32'(cmd_level), 32'(cq.size()));
    chk({tag, " R6 tc_value"}, 32'(tc_value), tc);
  endtask

  task automatic reg_write(logic [7:0] b);
    bit ov = model_push(cmd_mode, b);
    reg_wr_valid = 1'b1; reg_wr_data = b;
    @(posedge clk); @(negedge clk);
    reg_wr_valid = 1'b0;
    chk("R2 overrun after reg write", 32'(overrun), 32'(ov));
    check_state("reg write");
  endtask

  task automatic reg_read(bit flags);
    logic [7:0] e = flags ? 8'(dq.size()) : model_pop(1'b0);
    reg_rd_valid = 1'b1; reg_rd_flags = flags;
    @(posedge clk); @(negedge clk);
    reg_rd_valid = 1'b0;
    chk("R9/R3 reg rsp valid", 32'(reg_rsp_valid), 32'd1);
    chk(flags ? "R9 flags value" : "R2/R3 reg read byte", 32'(reg_rsp_data), 32'(e));
    check_state("reg read");
  endtask

  task automatic pdma_op(bit wr, bit wide, logic [15:0] wd);
    bit ov = 1'b0, seen = 1'b0, esvc;
    logic [15:0] erd = '0;
    logic [7:0] b0, b1;
    if (wr) begin
      for (int i = 0; i < (wide ? 2 : 1); i++) begin
        b0 = (wide && i == 0) ? wd[15:8] : wd[7:0];
        if (tc != 0) begin
          ov |= model_push(cmd_mode, b0);
          tc--;
        end
      end
      esvc = (tc == 0) || ((16 - dq.size()) < 2);
    end else begin
      b0 = model_pop(cmd_mode);
      b1 = wide ? model_pop(cmd_mode) : 8'h00;
      erd = wide ? {b0, b1} : {8'h00, b0};
      esvc = dq.size() < 2;
    end
    pdma_valid = 1'b1; pdma_write = wr; pdma_wide = wide; pdma_wdata = wd;
    @(posedge clk); @(negedge clk);
    pdma_valid = 1'b0;
    seen = overrun;
    if (wide) begin
      chk("R5 ready low mid halfword", 32'(pdma_ready), 32'd0);
      @(posedge clk); @(negedge clk);
      seen |= overrun;
    end
    chk(wr ? "R7 svc after write" : "R8 svc after read", 32'(svc_strobe), 32'(esvc));
    if (wr) chk("R2 overrun after pdma write", 32'(seen), 32'(ov));
    else begin
      chk("R5 pdma rsp valid", 32'(pdma_rsp_valid), 32'd1);
      chk("R5/R4 pdma read data", 32'(pdma_rsp_data), 32'(erd));
    end
    check_state("pdma");
  endtask

  task automatic do_flush(bit with_push);
    flush = 1'b1;
    if (with_push) begin reg_wr_valid = 1'b1; reg_wr_data = 8'hEE; end
    @(posedge clk); @(negedge clk);
    flush = 1'b0; reg_wr_valid = 1'b0;
    if (with_push && cmd_mode) void'(model_push(1'b1, 8'hEE));
    dq.delete();
    check_state("R10 flush");
  endtask

  task automatic load_tc(int unsigned v);
    tc_load = 1'b1; tc_load_val = 16'(v);
    @(posedge clk); @(negedge clk);
    tc_load = 1'b0;
    tc = v;
    check_state("R12 load");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data_level", 32'(data_level), 0);
    chk("R1 cmd_level", 32'(cmd_level), 0);
    chk("R1 tc_value", 32'(tc_value), 0);
    chk("R1 pdma_ready", 32'(pdma_ready), 1);
    chk("R1 quiet outputs", {28'd0, svc_strobe, overrun, reg_rsp_valid, pdma_rsp_valid}, 0);

    // R3 empty pops
    reg_read(1'b0);
    pdma_op(1'b0, 1'b1, 16'h0);
    // R2 fill past full, then drain in order
    for (int i = 0; i < 17; i++) reg_write(8'(8'h30 + i));
    reg_read(1'b1);
    for (int i = 0; i < 17; i++) reg_read(1'b0);
    // R4 command mode routing with halfwords, R5 lane order
    cmd_mode = 1'b1;
    load_tc(5);
    pdma_op(1'b1, 1'b1, 16'hA1B2);
    reg_write(8'h77);
    pdma_op(1'b0, 1'b1, 16'h0);
    pdma_op(1'b0, 1'b0, 16'h0);
    cmd_mode = 1'b0;
    // R6 count of one lets only the high byte in; then zero count ignores
    load_tc(1);
    pdma_op(1'b1, 1'b1, 16'hC3D4);
    pdma_op(1'b1, 1'b0, 16'h00E5);
    reg_read(1'b1);
    // R10 flush wins over simultaneous push
    reg_write(8'h11);
    do_flush(1'b1);
    // R12 load wins over decrement on the same edge
    load_tc(3);
    dq.push_back(8'h5A);
    tc_load = 1'b1; tc_load_val = 16'd9;
    pdma_valid = 1'b1; pdma_write = 1'b1; pdma_wide = 1'b0; pdma_wdata = 16'h005A;
    @(posedge clk); @(negedge clk);
    tc_load = 1'b0; pdma_valid = 1'b0; tc = 9;
    check_state("R12 load vs dec");
    // R11 back-pressure
    pdma_valid = 1'b1; reg_wr_valid = 1'b1; reg_rd_valid = 1'b1;
    #1;
    chk("R11 reg_wr_ready while pdma valid", 32'(reg_wr_ready), 0);
    chk("R11 reg_rd_ready while pdma valid", 32'(reg_rd_ready), 0);
    pdma_valid = 1'b0;
    #1;
    chk("R11 reg_rd_ready while reg write pending", 32'(reg_rd_ready), 0);
    reg_wr_valid = 1'b0; reg_rd_valid = 1'b0;
    @(negedge clk);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned k = $urandom_range(0, 11);
      case (k)
        0, 1:  reg_write(8'($urandom));
        2:     reg_read(1'b0);
        3:     reg_read(1'b1);
        4, 5:  pdma_op(1'b1, 1'($urandom), 16'($urandom));
        6, 7:  pdma_op(1'b0, 1'($urandom), 16'h0);
        8:     if ($urandom_range(0, 3) == 0) do_flush(1'($urandom));
        9:     load_tc($urandom_range(0, 24));
        default: begin cmd_mode = ~cmd_mode; @(negedge clk); end
      endcase
    end
    if (seed == 0) $display("seed zero");
    finish_run();
  end
endmodule